// File: doc/BRIEF.md
# Address-Messaging Interrupt Controller

This block gathers eleven level-sensitive interrupt lines and turns each new assertion into one 32-bit memory write towards the processor. Line 10 carries the serial-port request and line 6 the external-bus request; the others come from local and PCI sources. A live-level register follows the lines. Every low-to-high transition on a line whose live bit was clear queues one message. The message is sent on a request/acknowledge master port. The line's bit in a route-select register picks one of two programmable target registers. Each target register is split: the upper bits, with the low five bits cleared, form the write address, and the low five bits form the data word.

Software sees the two target registers, a mask, the route-select, a sticky pending register and three read-only views through a small word-indexed register port. The views are the live levels, the live lines that are masked in and routed to target A, and those routed to target B. The mask and the views never suppress a message. They only shape what software reads back. Edges that arrive while a message is outstanding wait in one request bit per line. After the acknowledge they are sent lowest line first.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset both target registers read CPU_BASE+3 (0xFFFE0003 by default), mask, select, pending and live read 0, and msg_req_o is low.
- R2: A rising level on line k whose live bit is clear sets live bit k and produces exactly one message; holding the line high produces no further message.
- R3: A falling level clears live bit k and produces no message.
- R4: A message for line k uses target B (word 1) when select bit k is set at launch, otherwise target A (word 0).
- R5: The message address is the chosen target with bits 4:0 cleared; the data word is the target's bits 4:0 zero-extended.
- R6: msg_req_o stays high with stable address and data until msg_ack_i is sampled high, and then drops for at least one cycle.
- R7: Edges captured while a message is outstanding are held per line and issued after the acknowledge, lowest line number first.
- R8: Word 5 reads live & mask & ~select, word 6 reads live & mask & select, and word 7 reads live (bit k = line k, zero-extended); the mask has no effect on message issue.
- R9: Each captured rising edge sets its bit in pending (word 4); any read or write of word 4 returns the old value and clears it, while an edge in that same cycle is kept.
- R10: Every register access is acknowledged on reg_ack_o one cycle later with reg_rdata_o; writes to words 5, 6 and 7 change no state. Map: 0 target A, 1 target B, 2 mask, 3 select, 4 pending, 5 view A, 6 view B, 7 live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | Interrupt levels, synchronous to clk_i |
| reg_req_i | input | 1 | Register access strobe, one cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | ADDR_W | Write data |
| reg_ack_o | output | 1 | Access acknowledge, one cycle after the strobe |
| reg_rdata_o | output | ADDR_W | Read data, valid with reg_ack_o |
| msg_req_o | output | 1 | Message write request |
| msg_addr_o | output | ADDR_W | Message write address |
| msg_data_o | output | ADDR_W | Message write data |
| msg_ack_i | input | 1 | Message write acknowledge |

## Verification
The assertions assume that irq_i is already synchronous to clk_i. They also assume msg_ack_i is raised only while msg_req_o is high, and that each register strobe lasts a single cycle. The bench drives every input on the falling edge and holds it for a full cycle. It raises the acknowledge only after it has seen a request, for one cycle. It issues each register access as a one-cycle strobe followed by an idle cycle. Lines are swept one at a time under both routes, then all together and in overlapping groups. This covers arbitration and queuing while a message is outstanding.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  typedef enum logic [2:0] {
    REG_TGT_A  = 3'd0,
    REG_TGT_B  = 3'd1,
    REG_MASK   = 3'd2,
    REG_SEL    = 3'd3,
    REG_PEND   = 3'd4,
    REG_VIEW_A = 3'd5,
    REG_VIEW_B = 3'd6,
    REG_LIVE   = 3'd7
  } reg_idx_e;

  localparam int unsigned REG_AW = 3;
endpackage

// File: rtl/irq_msg_capture.sv
module irq_msg_capture #(
  parameter int unsigned NUM_IRQ = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] req_clr_i,
  input  logic               pend_clr_i,
  output logic [NUM_IRQ-1:0] live_o,
  output logic [NUM_IRQ-1:0] req_o,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] live_q, req_q, pend_q, rise;

  assign rise = irq_i & ~live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      live_q <= irq_i;
      req_q  <= (req_q & ~req_clr_i) | rise;
      pend_q <= (pend_clr_i ? '0 : pend_q) | rise;
    end
  end

  assign live_o = live_q;
  assign req_o  = req_q;
  assign pend_o = pend_q;

  // R2
  live_rise_queues_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((live_q & ~$past(live_q)) & ~req_q) == '0);

  // R9
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr_i && (rise == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/irq_msg_sender.sv
module irq_msg_sender #(
  parameter int unsigned NUM_IRQ = 11,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFFS_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] req_i,
  input  logic [NUM_IRQ-1:0] sel_i,
  input  logic [ADDR_W-1:0]  tgt_a_i,
  input  logic [ADDR_W-1:0]  tgt_b_i,
  output logic [NUM_IRQ-1:0] clr_o,
  output logic               msg_req_o,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [ADDR_W-1:0]  msg_data_o,
  input  logic               msg_ack_i
);
  localparam int unsigned HI_W = ADDR_W - OFFS_W;

  logic               busy_q;
  logic [ADDR_W-1:0]  addr_q, data_q, tgt;
  logic [NUM_IRQ-1:0] grant;
  logic               launch;

  // lowest set bit wins
  assign grant  = req_i & (~req_i + NUM_IRQ'(1));
  assign launch = !busy_q && (req_i != '0);
  assign clr_o  = launch ? grant : '0;
  assign tgt    = ((grant & sel_i) != '0) ? tgt_b_i : tgt_a_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      addr_q <= {tgt[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
      data_q <= {{HI_W{1'b0}}, tgt[OFFS_W-1:0]};
    end else if (busy_q && msg_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign msg_req_o  = busy_q;
  assign msg_addr_o = addr_q;
  assign msg_data_o = data_q;

  // R6
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && !msg_ack_i) |=> (msg_req_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  // R6
  msg_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_req_o && msg_ack_i) |=> !msg_req_o);

  // R2
  msg_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_req_o) |-> ($past(req_i) != '0));

  // R7
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 11,
  parameter int unsigned ADDR_W   = 32,
  parameter logic [31:0] CPU_BASE = 32'hFFFE_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [ADDR_W-1:0]  reg_wdata_i,
  output logic               reg_ack_o,
  output logic [ADDR_W-1:0]  reg_rdata_o,
  input  logic [NUM_IRQ-1:0] live_i,
  input  logic [NUM_IRQ-1:0] pend_i,
  output logic               pend_clr_o,
  output logic [NUM_IRQ-1:0] mask_o,
  output logic [NUM_IRQ-1:0] sel_o,
  output logic [ADDR_W-1:0]  tgt_a_o,
  output logic [ADDR_W-1:0]  tgt_b_o
);
  localparam int unsigned PAD = ADDR_W - NUM_IRQ;
  localparam logic [ADDR_W-1:0] TGT_RST = ADDR_W'(CPU_BASE + 32'd3);

  logic [ADDR_W-1:0]  tgt_a_q, tgt_b_q, rd, rdata_q;
  logic [NUM_IRQ-1:0] mask_q, sel_q;
  logic               ack_q, wr;

  assign wr         = reg_req_i && reg_we_i;
  assign pend_clr_o = reg_req_i && (reg_addr_i == REG_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_a_q <= TGT_RST;
      tgt_b_q <= TGT_RST;
      mask_q  <= '0;
      sel_q   <= '0;
    end else if (wr) begin
      case (reg_idx_e'(reg_addr_i))
        REG_TGT_A: tgt_a_q <= reg_wdata_i;
        REG_TGT_B: tgt_b_q <= reg_wdata_i;
        REG_MASK:  mask_q  <= reg_wdata_i[NUM_IRQ-1:0];
        REG_SEL:   sel_q   <= reg_wdata_i[NUM_IRQ-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_idx_e'(reg_addr_i))
      REG_TGT_A:  rd = tgt_a_q;
      REG_TGT_B:  rd = tgt_b_q;
      REG_MASK:   rd = {{PAD{1'b0}}, mask_q};
      REG_SEL:    rd = {{PAD{1'b0}}, sel_q};
      REG_PEND:   rd = {{PAD{1'b0}}, pend_i};
      REG_VIEW_A: rd = {{PAD{1'b0}}, live_i & mask_q & ~sel_q};
      REG_VIEW_B: rd = {{PAD{1'b0}}, live_i & mask_q & sel_q};
      default:    rd = {{PAD{1'b0}}, live_i};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= reg_req_i;
      rdata_q <= (reg_req_i && !reg_we_i) ? rd : '0;
    end
  end

  assign reg_ack_o   = ack_q;
  assign reg_rdata_o = rdata_q;
  assign mask_o      = mask_q;
  assign sel_o       = sel_q;
  assign tgt_a_o     = tgt_a_q;
  assign tgt_b_o     = tgt_b_q;

  // R10
  reg_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i |=> reg_ack_o);

  // R10
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && reg_addr_i >= REG_VIEW_A) |=>
      ($stable(mask_q) && $stable(sel_q) && $stable(tgt_a_q) && $stable(tgt_b_q)));

  // R8
  view_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == REG_VIEW_A) |=>
      ((reg_rdata_o & ~{{PAD{1'b0}}, $past(mask_q & ~sel_q)}) == '0));

  // R8
  view_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i && reg_addr_i == REG_VIEW_B) |=>
      ((reg_rdata_o & ~{{PAD{1'b0}}, $past(mask_q & sel_q)}) == '0));
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 11,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned OFFS_W   = 5,
  parameter logic [31:0] CPU_BASE = 32'hFFFE_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reg_req_i,
  input  logic               reg_we_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [ADDR_W-1:0]  reg_wdata_i,
  output logic               reg_ack_o,
  output logic [ADDR_W-1:0]  reg_rdata_o,
  output logic               msg_req_o,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [ADDR_W-1:0]  msg_data_o,
  input  logic               msg_ack_i
);
  logic [NUM_IRQ-1:0] live, req, pend, clr, mask, sel;
  logic [ADDR_W-1:0]  tgt_a, tgt_b;
  logic               pend_clr;

  irq_msg_capture #(.NUM_IRQ(NUM_IRQ)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .req_clr_i  (clr),
    .pend_clr_i (pend_clr),
    .live_o     (live),
    .req_o      (req),
    .pend_o     (pend)
  );

  irq_msg_sender #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_sender (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .sel_i      (sel),
    .tgt_a_i    (tgt_a),
    .tgt_b_i    (tgt_b),
    .clr_o      (clr),
    .msg_req_o  (msg_req_o),
    .msg_addr_o (msg_addr_o),
    .msg_data_o (msg_data_o),
    .msg_ack_i  (msg_ack_i)
  );

  irq_msg_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .CPU_BASE(CPU_BASE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_req_i   (reg_req_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_ack_o   (reg_ack_o),
    .reg_rdata_o (reg_rdata_o),
    .live_i      (live),
    .pend_i      (pend),
    .pend_clr_o  (pend_clr),
    .mask_o      (mask),
    .sel_o       (sel),
    .tgt_a_o     (tgt_a),
    .tgt_b_o     (tgt_b)
  );

  // R5
  msg_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o |-> ((msg_addr_o[OFFS_W-1:0] == '0) && (msg_data_o[ADDR_W-1:OFFS_W] == '0)));

  // R3
  fall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(msg_req_o)) |-> ($past(req) != '0));
endmodule

// File: tb/irq_msg_ctrl_tb.sv
module irq_msg_ctrl_tb;
  localparam int N = 11;
  localparam logic [31:0] BASE = 32'hFFFE_0000;
  localparam logic [31:0] TA = 32'h1234_5667;
  localparam logic [31:0] TB = 32'hABCD_EF1F;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [N-1:0] irq;
  logic        reg_req, reg_we, reg_ack, msg_req, msg_ack;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, msg_addr, msg_data, rd;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_msg_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_ack_o(reg_ack), .reg_rdata_o(reg_rdata),
    .msg_req_o(msg_req), .msg_addr_o(msg_addr), .msg_data_o(msg_data),
    .msg_ack_i(msg_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_req = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk); reg_req = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d, output bit acked);
    @(negedge clk); reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_req = 1'b0; reg_we = 1'b0;
    acked = reg_ack;
  endtask

  function automatic logic [31:0] exp_tgt(input int k, input logic [N-1:0] s);
    return s[k] ? TB : TA;
  endfunction

  task automatic wait_msg(input logic [31:0] t, input string tag);
    logic [31:0] a0;
    for (int n = 0; n < 100 && !msg_req; n++) @(negedge clk);
    chk(msg_req, {tag, " R2 request"}, {31'b0, msg_req}, 32'd1);
    chk(msg_addr == {t[31:5], 5'b0}, {tag, " R4/R5 address"}, msg_addr, {t[31:5], 5'b0});
    chk(msg_data == {27'b0, t[4:0]}, {tag, " R5 data"}, msg_data, {27'b0, t[4:0]});
    a0 = msg_addr;
    @(negedge clk);
    chk(msg_req && msg_addr == a0, {tag, " R6 hold"}, msg_addr, a0);
    msg_ack = 1'b1;
    @(negedge clk); msg_ack = 1'b0;
    chk(!msg_req, {tag, " R6 drop after ack"}, {31'b0, msg_req}, 32'd0);
  endtask

  task automatic no_msg(input int cyc, input string tag);
    bit seen = 1'b0;
    for (int n = 0; n < cyc; n++) begin @(negedge clk); seen |= msg_req; end
    chk(!seen, tag, {31'b0, seen}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    bit ack;
    logic [N-1:0] s;
    logic [N-1:0] masks [4] = '{11'h7FF, 11'h0F0, 11'h321, 11'h000};
    logic [N-1:0] sels  [3] = '{11'h555, 11'h0FF, 11'h7FF};
    rst_ni = 1'b0; irq = '0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; msg_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk(!msg_req, "R1 msg_req", {31'b0, msg_req}, 32'd0);
    reg_rd(3'd0, rd); chk(rd == BASE + 3, "R1 target A", rd, BASE + 3);
    reg_rd(3'd1, rd); chk(rd == BASE + 3, "R1 target B", rd, BASE + 3);
    for (int w = 2; w < 8; w++) begin
      reg_rd(3'(w), rd); chk(rd == 0, $sformatf("R1 word %0d", w), rd, 0);
    end

    reg_wr(3'd0, TA, ack);
    reg_wr(3'd1, TB, ack);

    // sweep every line under both routes; mask stays 0 (R8: mask does not gate messages)
    for (int k = 0; k < N; k++) begin
      for (int r = 0; r < 2; r++) begin
        s = r ? N'(1) << k : '0;
        reg_wr(3'd3, {21'b0, s}, ack);
        @(negedge clk); irq[k] = 1'b1;
        wait_msg(exp_tgt(k, s), $sformatf("line %0d route %0d", k, r));
        no_msg(4, "R2 held high no repeat");
        reg_rd(3'd7, rd); chk(rd == 32'(1) << k, "R2 live set", rd, 32'(1) << k);
        @(negedge clk); irq[k] = 1'b0;
        no_msg(4, "R3 falling edge no message");
        reg_rd(3'd7, rd); chk(rd == 0, "R3 live cleared", rd, 0);
      end
    end

    // R7 all lines at once, lowest first
    s = 11'h555;
    reg_wr(3'd3, {21'b0, s}, ack);
    @(negedge clk); irq = '1;
    for (int k = 0; k < N; k++) wait_msg(exp_tgt(k, s), $sformatf("R7 burst order line %0d", k));
    no_msg(5, "R7 burst no extra");

    // R8 view sweep with all lines high
    foreach (masks[i]) foreach (sels[j]) begin
      reg_wr(3'd2, {21'b0, masks[i]}, ack);
      reg_wr(3'd3, {21'b0, sels[j]}, ack);
      reg_rd(3'd5, rd);
      chk(rd == {21'b0, masks[i] & ~sels[j]}, "R8 view A", rd, {21'b0, masks[i] & ~sels[j]});
      reg_rd(3'd6, rd);
      chk(rd == {21'b0, masks[i] & sels[j]}, "R8 view B", rd, {21'b0, masks[i] & sels[j]});
    end
    no_msg(2, "R8 select change no message");
    reg_wr(3'd2, 32'h7FF, ack);
    reg_wr(3'd3, 32'h555, ack);
    @(negedge clk); irq = 11'h7C0;
    reg_rd(3'd7, rd); chk(rd == 32'h7C0, "R8 partial live", rd, 32'h7C0);
    reg_rd(3'd5, rd); chk(rd == 32'h280, "R8 partial view A", rd, 32'h280);
    reg_rd(3'd6, rd); chk(rd == 32'h540, "R8 partial view B", rd, 32'h540);
    @(negedge clk); irq = '0;
    no_msg(3, "R3 group fall no message");

    // R9 pending
    reg_rd(3'd4, rd); chk(rd == 32'h7FF, "R9 pending accumulated", rd, 32'h7FF);
    reg_rd(3'd4, rd); chk(rd == 0, "R9 cleared by read", rd, 0);
    @(negedge clk); irq[3] = 1'b1;
    wait_msg(TA, "R9 line 3");
    reg_rd(3'd4, rd); chk(rd == 32'h008, "R9 single edge", rd, 32'h008);
    reg_rd(3'd4, rd); chk(rd == 0, "R9 cleared again", rd, 0);
    @(negedge clk); irq[5] = 1'b1;
    wait_msg(TA, "R9 line 5");
    reg_wr(3'd4, 32'hFFFF_FFFF, ack);
    reg_rd(3'd4, rd); chk(rd == 0, "R9 cleared by write", rd, 0);
    @(negedge clk); irq = '0;

    // R10 read-only words ignore writes
    @(negedge clk); irq[2] = 1'b1;
    wait_msg(TB, "R10 line 2");
    reg_wr(3'd7, 32'h0, ack); chk(ack, "R10 ack on RO write", {31'b0, ack}, 1);
    reg_wr(3'd5, 32'h7FF, ack); chk(ack, "R10 ack on view write", {31'b0, ack}, 1);
    reg_wr(3'd6, 32'h7FF, ack);
    reg_rd(3'd7, rd); chk(rd == 32'h004, "R10 live unchanged", rd, 32'h004);
    reg_rd(3'd2, rd); chk(rd == 32'h7FF, "R10 mask unchanged", rd, 32'h7FF);
    reg_rd(3'd3, rd); chk(rd == 32'h555, "R10 select unchanged", rd, 32'h555);
    reg_rd(3'd0, rd); chk(rd == TA, "R10 target A unchanged", rd, TA);
    @(negedge clk); irq = '0;
    no_msg(3, "R3 line 2 fall");

    // R7 edges during an outstanding message
    reg_wr(3'd3, 32'h002, ack);
    @(negedge clk); irq[9] = 1'b1;
    for (int n = 0; n < 100 && !msg_req; n++) @(negedge clk);
    chk(msg_addr == {TA[31:5], 5'b0}, "R7 line 9 first", msg_addr, {TA[31:5], 5'b0});
    irq[4] = 1'b1; irq[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk(msg_req && msg_addr == {TA[31:5], 5'b0}, "R7 outstanding held", msg_addr, {TA[31:5], 5'b0});
    msg_ack = 1'b1;
    @(negedge clk); msg_ack = 1'b0;
    wait_msg(TB, "R7 queued line 1");
    wait_msg(TA, "R7 queued line 4");
    no_msg(4, "R7 queue drained");
    irq = '0;

    finish_sim();
  end
endmodule